// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps the reservation for one processor's atomic read-modify-write sequence. A load-locked request marks a reservation and records which aligned 16-byte granule holds the target. A later store-conditional is checked against that reservation. The store reaches memory only if the reservation is still intact. In every case a status bit goes back for the destination register: 1 means the store was written and 0 means it was dropped. Software uses a failed status to repeat its sequence.

Two kinds of event break a reservation. The first is a write by another agent, seen on the snoop port, that lands anywhere in the reserved granule. The second is an exception or interrupt taken by the local processor. Both requests work only on naturally aligned 32-bit or 64-bit data. A misaligned request raises a fault and leaves the reservation as it was. All outputs are registered, so every result appears one clock after the request.

Top module: `rsv_monitor`

## Requirements
- R1: Request size `req_size` is 0 for 32-bit data and 1 for 64-bit data. A 32-bit request needs `req_addr[1:0]==0` and a 64-bit request needs `req_addr[2:0]==0`. A misaligned load-locked or store-conditional raises `align_fault` in the next cycle. It produces no response and no memory write, and it leaves the reservation unchanged.
- R2: An aligned load-locked (`req_op`=2'b01) sets the reservation to the granule `req_addr[AW-1:4]`. Any earlier reservation is replaced.
- R3: An aligned store-conditional (`req_op`=2'b10) succeeds when three conditions hold: a reservation is held, its granule equals `req_addr[AW-1:4]`, and no clearing event occurs in that cycle. On success, the next cycle shows `mem_wr_valid`=1 with the request's address, data and size, together with `rsp_valid`=1 and `rsp_status`=1.
- R4: A store-conditional that does not succeed produces `rsp_valid`=1 and `rsp_status`=0 in the next cycle, and `mem_wr_valid` stays 0.
- R5: Every aligned store-conditional drops the reservation, whether it passes or fails.
- R6: A snooped write (`snp_wr_valid`) whose address matches the reserved granule, with the low 4 bits ignored, drops the reservation. A snooped write to any other granule has no effect on it.
- R7: `trap_evt` (a local exception or interrupt) drops the reservation.
- R8: If a store-conditional arrives in the same cycle as a snooped write to the reserved granule, or in the same cycle as `trap_evt`, it fails.
- R9: If a load-locked arrives in the same cycle as `trap_evt`, or in the same cycle as a snooped write to the new granule, no reservation is left. A snooped write that hits only the old granule does not stop the new reservation from being set.
- R10: After reset, no reservation is held and all outputs are 0. `req_op` values 2'b00 and 2'b11 are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 00 idle, 01 load-locked, 10 store-conditional, 11 idle |
| req_size | input | 1 | 0 = 32-bit, 1 = 64-bit |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Store-conditional data |
| snp_wr_valid | input | 1 | Another agent writes this cycle |
| snp_wr_addr | input | AW | Address of that write |
| trap_evt | input | 1 | Local exception or interrupt taken |
| mem_wr_valid | output | 1 | Forwarded store this cycle |
| mem_wr_addr | output | AW | Store address |
| mem_wr_data | output | DW | Store data |
| mem_wr_size | output | 1 | Store size |
| rsp_valid | output | 1 | Store-conditional status valid |
| rsp_status | output | 1 | 1 = stored, 0 = failed |
| align_fault | output | 1 | Misaligned atomic request |

## Verification
Three events can land on the same clock edge: a store-conditional check or a new load-locked, a remote write seen on the snoop port, and a local trap. The bench schedules these coincidences on purpose. It aims snooped writes at every offset inside the reserved granule and at neighbouring granules, and it raises the trap in the same cycle as each kind of request. For each case it judges the outcome by what follows: whether the store reached memory, which status came back, and what a later store-conditional to the same granule returns.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_NONE = 2'b11
  } rsv_op_e;

  typedef enum logic {
    SZ_WORD32 = 1'b0,
    SZ_WORD64 = 1'b1
  } rsv_size_e;
endpackage

// File: rtl/rsv_align_chk.sv
module rsv_align_chk
  import rsv_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    op,
  input  logic          size,
  input  logic [AW-1:0] addr,
  output logic          ll_ok,
  output logic          sc_ok,
  output logic          fault
);
  rsv_op_e op_e;
  logic    atomic;
  logic    aligned;

  always_comb begin
    op_e    = rsv_op_e'(op);
    atomic  = (op_e == OP_LL) || (op_e == OP_SC);
    if (rsv_size_e'(size) == SZ_WORD64) aligned = (addr[2:0] == 3'b000);
    else                                aligned = (addr[1:0] == 2'b00);
    ll_ok   = (op_e == OP_LL) && aligned;
    sc_ok   = (op_e == OP_SC) && aligned;
    fault   = atomic && !aligned;
  end
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker #(
  parameter int AW      = 32,
  parameter int GRAN_LG = 4,
  localparam int GW     = AW - GRAN_LG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ll_ok,
  input  logic          sc_ok,
  input  logic [GW-1:0] req_gran,
  input  logic          snp_v,
  input  logic [GW-1:0] snp_gran,
  input  logic          trap,
  output logic          sc_pass,
  output logic          lock_valid,
  output logic [GW-1:0] lock_gran
);
  logic hit_old;
  logic hit_new;
  logic valid_d;
  logic [GW-1:0] gran_d;

  always_comb begin
    hit_old = snp_v && lock_valid && (snp_gran == lock_gran);
    hit_new = snp_v && (snp_gran == req_gran);
    sc_pass = sc_ok && lock_valid && (req_gran == lock_gran) && !trap && !hit_old;
    valid_d = lock_valid;
    gran_d  = lock_gran;
    if (ll_ok) begin
      valid_d = !(trap || hit_new);
      gran_d  = req_gran;
    end else if (sc_ok || trap || hit_old) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_valid <= 1'b0;
      lock_gran  <= '0;
    end else begin
      lock_valid <= valid_d;
      lock_gran  <= gran_d;
    end
  end
endmodule

// File: rtl/rsv_out_reg.sv
module rsv_out_reg #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sc_ok,
  input  logic          sc_pass,
  input  logic          fault,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          size,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_wr_size,
  output logic          rsp_valid,
  output logic          rsp_status,
  output logic          align_fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_wr_size  <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_status   <= 1'b0;
      align_fault  <= 1'b0;
    end else begin
      mem_wr_valid <= sc_pass;
      rsp_valid    <= sc_ok;
      rsp_status   <= sc_pass;
      align_fault  <= fault;
      if (sc_pass) begin
        mem_wr_addr <= addr;
        mem_wr_data <= wdata;
        mem_wr_size <= size;
      end
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int GRAN_LG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    req_op,
  input  logic          req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snp_wr_valid,
  input  logic [AW-1:0] snp_wr_addr,
  input  logic          trap_evt,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_wr_size,
  output logic          rsp_valid,
  output logic          rsp_status,
  output logic          align_fault
);
  localparam int GW = AW - GRAN_LG;

  logic          ll_ok;
  logic          sc_ok;
  logic          fault;
  logic          sc_pass;
  logic          lock_valid;
  logic [GW-1:0] lock_gran;

  rsv_align_chk #(.AW(AW)) u_align (
    .op    (req_op),
    .size  (req_size),
    .addr  (req_addr),
    .ll_ok (ll_ok),
    .sc_ok (sc_ok),
    .fault (fault)
  );

  rsv_tracker #(.AW(AW), .GRAN_LG(GRAN_LG)) u_track (
    .clk        (clk),
    .rst        (rst),
    .ll_ok      (ll_ok),
    .sc_ok      (sc_ok),
    .req_gran   (req_addr[AW-1:GRAN_LG]),
    .snp_v      (snp_wr_valid),
    .snp_gran   (snp_wr_addr[AW-1:GRAN_LG]),
    .trap       (trap_evt),
    .sc_pass    (sc_pass),
    .lock_valid (lock_valid),
    .lock_gran  (lock_gran)
  );

  rsv_out_reg #(.AW(AW), .DW(DW)) u_out (
    .clk          (clk),
    .rst          (rst),
    .sc_ok        (sc_ok),
    .sc_pass      (sc_pass),
    .fault        (fault),
    .addr         (req_addr),
    .wdata        (req_wdata),
    .size         (req_size),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_size  (mem_wr_size),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .align_fault  (align_fault)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int AW      = 32,
  parameter int GRAN_LG = 4,
  localparam int GW     = AW - GRAN_LG
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          snp_wr_valid,
  input logic [AW-1:0] snp_wr_addr,
  input logic          trap_evt,
  input logic          lock_valid,
  input logic [GW-1:0] lock_gran,
  input logic          mem_wr_valid,
  input logic          rsp_valid,
  input logic          rsp_status,
  input logic          align_fault
);
  p_fault_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!mem_wr_valid && !rsp_valid));

  p_lock_from_ll_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_valid) |-> ($past(req_op) == 2'b01));

  p_write_has_pass_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (rsp_valid && rsp_status));

  p_fail_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_status) |-> !mem_wr_valid);

  p_sc_drops_lock_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !lock_valid);

  p_snoop_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (snp_wr_valid && lock_valid && (snp_wr_addr[AW-1:GRAN_LG] == lock_gran)
     && (req_op != 2'b01)) |=> !lock_valid);

  p_trap_drop_r7: assert property (@(posedge clk) disable iff (rst)
    trap_evt |=> !lock_valid);

  p_same_cycle_fail_r8: assert property (@(posedge clk) disable iff (rst)
    ((req_op == 2'b10) && (trap_evt || (snp_wr_valid && lock_valid &&
      (snp_wr_addr[AW-1:GRAN_LG] == lock_gran)))) |=> !rsp_status);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!lock_valid && !rsp_valid && !mem_wr_valid && !align_fault));
endmodule

bind rsv_monitor rsv_monitor_chk #(.AW(AW), .GRAN_LG(GRAN_LG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_op       (req_op),
  .req_addr     (req_addr),
  .snp_wr_valid (snp_wr_valid),
  .snp_wr_addr  (snp_wr_addr),
  .trap_evt     (trap_evt),
  .lock_valid   (lock_valid),
  .lock_gran    (lock_gran),
  .mem_wr_valid (mem_wr_valid),
  .rsp_valid    (rsp_valid),
  .rsp_status   (rsp_status),
  .align_fault  (align_fault)
);

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    req_op = 2'b00;
  logic          req_size = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snp_wr_valid = 1'b0;
  logic [AW-1:0] snp_wr_addr = '0;
  logic          trap_evt = 1'b0;
  logic          mem_wr_valid, mem_wr_size, rsp_valid, rsp_status, align_fault;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit       m_valid = 0;
  bit [3:0] m_gran = 0;

  always #2 clk = ~clk;

  rsv_monitor #(.AW(AW), .DW(DW), .GRAN_LG(4)) u_dut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .snp_wr_valid(snp_wr_valid), .snp_wr_addr(snp_wr_addr), .trap_evt(trap_evt),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_size(mem_wr_size),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .align_fault(align_fault)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] op, logic sz, logic [7:0] a,
                      logic sv, logic [7:0] sa, logic tr);
    bit aligned, isll, issc, hit_old, pass, e_fault;
    logic [DW-1:0] d;
    d = {a, sa} ^ 16'h5a3c;
    req_op = op; req_size = sz; req_addr = a; req_wdata = d;
    snp_wr_valid = sv; snp_wr_addr = sa; trap_evt = tr;
    aligned = sz ? (a[2:0] == 3'b000) : (a[1:0] == 2'b00);
    e_fault = ((op == 2'b01) || (op == 2'b10)) && !aligned;
    isll    = (op == 2'b01) && aligned;
    issc    = (op == 2'b10) && aligned;
    hit_old = sv && m_valid && (sa[7:4] == m_gran);
    pass    = issc && m_valid && (a[7:4] == m_gran) && !tr && !hit_old;
    if (isll) begin
      m_valid = !(tr || (sv && sa[7:4] == a[7:4]));
      m_gran  = a[7:4];
    end else if (issc || tr || hit_old) begin
      m_valid = 0;
    end
    @(negedge clk);
    chk(tag, "align_fault", align_fault, e_fault);
    chk(tag, "rsp_valid", rsp_valid, issc);
    chk(tag, "rsp_status", rsp_status, pass);
    chk(tag, "mem_wr_valid", mem_wr_valid, pass);
    if (pass) begin
      chk(tag, "mem_wr_addr", mem_wr_addr, a);
      chk(tag, "mem_wr_data", mem_wr_data, d);
      chk(tag, "mem_wr_size", mem_wr_size, sz);
    end
  endtask

  task automatic idle();
    step("R10", 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: outputs cleared, no reservation after reset, op 11 idle
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "mem_wr_valid", mem_wr_valid, 0);
    chk("R10", "align_fault", align_fault, 0);
    step("R10", 2'b11, 1'b1, 8'h20, 1'b0, 8'h00, 1'b0);
    step("R10", 2'b10, 1'b1, 8'h20, 1'b0, 8'h00, 1'b0);

    // R2/R3/R4/R5: LL at every 8-byte slot, SC at every 4-byte slot
    for (int la = 0; la < 32; la++) begin
      for (int sa = 0; sa < 64; sa++) begin
        logic [7:0] ll_a, sc_a;
        ll_a = 8'(la * 8);
        sc_a = 8'(sa * 4);
        step("R2", 2'b01, 1'b1, ll_a, 1'b0, 8'h00, 1'b0);
        step((sc_a[7:4] == ll_a[7:4]) ? "R3" : "R4", 2'b10, ~sc_a[2], sc_a,
             1'b0, 8'h00, 1'b0);
      end
    end

    // R5: second SC after success fails; R2: replacement
    step("R2", 2'b01, 1'b0, 8'h34, 1'b0, 8'h00, 1'b0);
    step("R3", 2'b10, 1'b0, 8'h38, 1'b0, 8'h00, 1'b0);
    step("R5", 2'b10, 1'b0, 8'h38, 1'b0, 8'h00, 1'b0);
    step("R2", 2'b01, 1'b0, 8'h34, 1'b0, 8'h00, 1'b0);
    step("R2", 2'b01, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0);
    step("R2", 2'b10, 1'b0, 8'h34, 1'b0, 8'h00, 1'b0);
    step("R2", 2'b01, 1'b0, 8'h34, 1'b0, 8'h00, 1'b0);
    step("R2", 2'b01, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0);
    step("R3", 2'b10, 1'b1, 8'h98, 1'b0, 8'h00, 1'b0);

    // R1: misaligned LL/SC leaves reservation intact
    for (int a = 0; a < 16; a++) begin
      for (int s = 0; s < 2; s++) begin
        for (int o = 1; o < 3; o++) begin
          step("R1", 2'b01, 1'b1, 8'h40, 1'b0, 8'h00, 1'b0);
          step("R1", 2'(o), 1'(s), 8'(8'h48 + a), 1'b0, 8'h00, 1'b0);
          step("R1", 2'b10, 1'b0, 8'h44, 1'b0, 8'h00, 1'b0);
        end
      end
    end

    // R6: snooped write at every address, idle cycle between LL and SC
    for (int sa = 0; sa < 256; sa++) begin
      step("R6", 2'b01, 1'b1, 8'h80, 1'b0, 8'h00, 1'b0);
      step("R6", 2'b00, 1'b0, 8'h00, 1'b1, 8'(sa), 1'b0);
      step("R6", 2'b10, 1'b1, 8'h88, 1'b0, 8'h00, 1'b0);
    end

    // R7: trap between LL and SC
    step("R7", 2'b01, 1'b0, 8'hc4, 1'b0, 8'h00, 1'b0);
    step("R7", 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    step("R7", 2'b10, 1'b0, 8'hc4, 1'b0, 8'h00, 1'b0);
    step("R7", 2'b01, 1'b0, 8'hc4, 1'b0, 8'h00, 1'b0);
    idle();
    step("R7", 2'b10, 1'b0, 8'hc4, 1'b0, 8'h00, 1'b0);

    // R8: coincident snoop or trap with SC
    for (int off = 0; off < 32; off++) begin
      step("R8", 2'b01, 1'b1, 8'h50, 1'b0, 8'h00, 1'b0);
      step("R8", 2'b10, 1'b1, 8'h58, 1'b1, 8'(8'h50 + off), 1'b0);
    end
    step("R8", 2'b01, 1'b1, 8'h50, 1'b0, 8'h00, 1'b0);
    step("R8", 2'b10, 1'b1, 8'h50, 1'b0, 8'h00, 1'b1);

    // R9: coincident snoop or trap with LL
    for (int off = 0; off < 48; off++) begin
      step("R9", 2'b01, 1'b0, 8'h10, 1'b0, 8'h00, 1'b0);
      step("R9", 2'b01, 1'b0, 8'h24, 1'b1, 8'(8'h10 + off), 1'b0);
      step("R9", 2'b10, 1'b0, 8'h2c, 1'b0, 8'h00, 1'b0);
    end
    step("R9", 2'b01, 1'b0, 8'h24, 1'b0, 8'h00, 1'b1);
    step("R9", 2'b10, 1'b0, 8'h24, 1'b0, 8'h00, 1'b0);

    // R10: reset mid-reservation clears it
    step("R10", 2'b01, 1'b0, 8'he0, 1'b0, 8'h00, 1'b0);
    rst = 1'b1;
    m_valid = 0;
    @(negedge clk);
    rst = 1'b0;
    step("R10", 2'b10, 1'b0, 8'he0, 1'b0, 8'h00, 1'b0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule